// File: doc/BRIEF.md
# Periodic Time-Triggered Send Scheduler

This block decides when each of a small set of message slots may send. Every slot keeps one state message and a timing setting made of a 4-bit period code and a 12-bit phase. The period code picks one bit of the free-running 64-bit global time. That bit marks a power-of-two period. The phase is checked against the time bits just below that bit. The first cycle in which they agree, the slot raises a one-cycle trigger. If a message is waiting in the slot, that message is handed to a release unit, which presents it on a single transmit port.

Each slot buffer behaves as state storage, not as a queue. A write replaces whatever the slot held and marks the slot as holding a message to send. A trigger consumes that mark, but the buffer contents stay readable. When several slots fire in the same cycle, the release unit emits them one per cycle in ascending slot index, so the send order is fixed in advance.

Each slot runs a three-state machine. SL_OFF is disabled. SL_WAIT is armed, with no match seen yet. SL_FIRED means the match is still true after a trigger. A configuration write moves a slot to SL_WAIT if the write enables it and to SL_OFF if it does not. SL_WAIT moves to SL_FIRED when the match appears, and that transition is the trigger. SL_FIRED returns to SL_WAIT when the match goes away. SL_OFF stays put until the next configuration write.

The release unit has two states. RL_IDLE moves to RL_DRAIN when any trigger with a held message arrives, and it latches that cycle's requests as a batch. RL_DRAIN emits the lowest slot in the batch each cycle. Requests that arrive meanwhile collect in a waiting set. When the batch empties, RL_DRAIN reloads from the waiting set and stays in RL_DRAIN, or returns to RL_IDLE if the waiting set is empty.

Top module: `tts_sched`

## Requirements
- R1: Period code c (0 to 15) makes time bit 25-c the period bit. Phase bit i is compared with time bit 13-c+i. For example, code 0 compares time[24:13], code 13 compares time[11:0], and code 15 uses time bit 10 as the period bit.
- R2: Time bits at and above the period bit do not affect the match. Time bits below the lowest compared bit do not affect it either.
- R3: For codes 14 and 15, the low phase bits that would fall below time bit 0 are ignored. For code 14 that is phase[0], and for code 15 it is phase[1:0]. Only the remaining phase bits are compared, against time[10:0] and time[9:0] respectively.
- R4: For an enabled slot, trig_o[s] is high for exactly the one cycle in which the match first becomes true. The match must go false again before the slot can fire again. trig_o follows gtime_i in the same cycle.
- R5: A configuration write (cfg_we_i with cfg_slot_i) takes effect from the next cycle. A slot written with cfg_en_i=0 never triggers.
- R6: A buffer write replaces the slot's previous message. rd_data_o for that slot shows the new value from the cycle after the write, and other slots are unchanged.
- R7: A trigger on a slot holding an unsent message makes tx_valid_o high with that slot's index and data two cycles after the trigger cycle, and the slot then holds nothing. A trigger on a slot with nothing held produces no transmit.
- R8: Slots that trigger together with held messages are transmitted on consecutive cycles in ascending slot index.
- R9: After reset, all slots are disabled, every buffer reads zero, and trig_o and tx_valid_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gtime_i | input | 64 | Global time: 24 fraction bits below 40 seconds bits |
| cfg_we_i | input | 1 | Slot configuration write strobe |
| cfg_slot_i | input | SLOT_W | Slot being configured |
| cfg_en_i | input | 1 | Enable for the configured slot |
| cfg_code_i | input | 4 | Period code for the configured slot |
| cfg_phase_i | input | 12 | Phase for the configured slot |
| wr_en_i | input | 1 | Message buffer write strobe |
| wr_slot_i | input | SLOT_W | Slot whose buffer is written |
| wr_data_i | input | MSG_W | Message written into the buffer |
| rd_slot_i | input | SLOT_W | Slot whose buffer is read |
| rd_data_o | output | MSG_W | Contents of the selected buffer |
| trig_o | output | NUM_SLOTS | One-cycle send trigger per slot |
| tx_valid_o | output | 1 | Released message valid |
| tx_slot_o | output | SLOT_W | Slot of the released message |
| tx_data_o | output | MSG_W | Released message |

## Verification
Some properties are checked by assertions on every cycle. These are: a trigger never repeats in the following cycle, a disabled slot stays silent, a write leaves the slot holding exactly the written message, a trigger clears the held mark, the release unit emits in every draining cycle, and grants within one batch rise in slot index. The bench scenarios cover what only a reference model can show. These are the exact bit field each period code compares, the ignored high bits and missing low phase bits, and the trigger pattern over exhaustive sweeps of the compared time bits. The scenarios also cover the two-cycle release latency with the contents actually transmitted, and the fact that a slot with no held message stays silent on the transmit port.

// File: rtl/tts_pkg.sv
package tts_pkg;

    localparam int TIME_W     = 64;
    localparam int PH_W       = 12;
    localparam int CODE_W     = 4;
    // time bit used as period bit for code 0; code c uses TOP_BIT - c
    localparam int TOP_BIT    = 25;
    localparam int TIDX_W     = $clog2(TIME_W);

    typedef enum logic [1:0] {
        SL_OFF   = 2'd0,
        SL_WAIT  = 2'd1,
        SL_FIRED = 2'd2
    } slot_st_e;

    typedef enum logic {
        RL_IDLE  = 1'b0,
        RL_DRAIN = 1'b1
    } rel_st_e;

    typedef struct packed {
        logic              en;
        logic [CODE_W-1:0] code;
        logic [PH_W-1:0]   phase;
    } slot_cfg_t;

endpackage

// File: rtl/tts_phase_match.sv
module tts_phase_match
    import tts_pkg::*;
(
    input  logic [TIME_W-1:0] gtime_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic [PH_W-1:0]   phase_i,
    output logic              match_o
);

    // lowest compared time bit for code 0
    localparam int BASE = TOP_BIT - PH_W;

    int tb;

    always_comb begin
        match_o = 1'b1;
        tb      = 0;
        for (int i = 0; i < PH_W; i++) begin
            tb = BASE - int'(code_i) + i;
            // phase bits that would sit below time bit 0 are not compared
            if (tb >= 0) begin
                if (gtime_i[tb[TIDX_W-1:0]] != phase_i[i]) begin
                    match_o = 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/tts_slot.sv
module tts_slot
    import tts_pkg::*;
#(
    parameter int MSG_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TIME_W-1:0] gtime_i,
    input  logic              cfg_hit_i,
    input  slot_cfg_t         cfg_i,
    input  logic              wr_hit_i,
    input  logic [MSG_W-1:0]  wr_data_i,
    output logic              trig_o,
    output logic              rel_req_o,
    output logic [MSG_W-1:0]  buf_o
);

    slot_cfg_t  cfg_q;
    slot_st_e   st_q, st_n;
    logic       match;
    logic       held_q;

    tts_phase_match u_match (
        .gtime_i (gtime_i),
        .code_i  (cfg_q.code),
        .phase_i (cfg_q.phase),
        .match_o (match)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (cfg_hit_i) begin
            cfg_q <= cfg_i;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= SL_OFF;
        end else begin
            st_q <= st_n;
        end
    end

    // next state
    always_comb begin
        st_n = st_q;
        if (cfg_hit_i) begin
            st_n = cfg_i.en ? SL_WAIT : SL_OFF;
        end else begin
            unique case (st_q)
                SL_OFF:   st_n = SL_OFF;
                SL_WAIT:  if (match)  st_n = SL_FIRED;
                SL_FIRED: if (!match) st_n = SL_WAIT;
                default:  st_n = SL_OFF;
            endcase
        end
    end

    // outputs
    always_comb begin
        trig_o    = (st_q == SL_WAIT) && match;
        rel_req_o = trig_o && held_q;
    end

    // state-message buffer: newest write wins, trigger consumes the held mark
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_o  <= '0;
            held_q <= 1'b0;
        end else if (wr_hit_i) begin
            buf_o  <= wr_data_i;
            held_q <= 1'b1;
        end else if (trig_o) begin
            held_q <= 1'b0;
        end
    end

    // R4
    trig_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_o && !cfg_hit_i) |=> !trig_o);

    // R5
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_hit_i && !cfg_i.en) |=> !trig_o);

    // R6
    wr_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit_i |=> (held_q && (buf_o == $past(wr_data_i))));

    // R7
    held_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_o && !wr_hit_i) |=> !held_q);

endmodule

// File: rtl/tts_release.sv
module tts_release
    import tts_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int MSG_W     = 32,
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_SLOTS-1:0]       req_i,
    input  logic [NUM_SLOTS*MSG_W-1:0] bufs_i,
    output logic                       tx_valid_o,
    output logic [SLOT_W-1:0]          tx_slot_o,
    output logic [MSG_W-1:0]           tx_data_o
);

    rel_st_e              st_q, st_n;
    logic [NUM_SLOTS-1:0] batch_q, batch_n;
    logic [NUM_SLOTS-1:0] pend_q, pend_n;
    logic [NUM_SLOTS-1:0] grant, rest;
    logic [SLOT_W-1:0]    gidx;
    logic                 last_q;

    // lowest set bit of the current batch
    always_comb begin
        gidx  = '0;
        grant = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (batch_q[i]) begin
                gidx  = SLOT_W'(i);
                grant = NUM_SLOTS'(1) << i;
            end
        end
        rest = batch_q & ~grant;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= RL_IDLE;
            batch_q <= '0;
            pend_q  <= '0;
        end else begin
            st_q    <= st_n;
            batch_q <= batch_n;
            pend_q  <= pend_n;
        end
    end

    // next state
    always_comb begin
        st_n    = st_q;
        batch_n = batch_q;
        pend_n  = pend_q;
        unique case (st_q)
            RL_IDLE: begin
                batch_n = req_i;
                pend_n  = '0;
                st_n    = (req_i != '0) ? RL_DRAIN : RL_IDLE;
            end
            RL_DRAIN: begin
                if (rest == '0) begin
                    batch_n = pend_q | req_i;
                    pend_n  = '0;
                    st_n    = ((pend_q | req_i) != '0) ? RL_DRAIN : RL_IDLE;
                end else begin
                    batch_n = rest;
                    pend_n  = pend_q | req_i;
                end
            end
            default: begin
                st_n    = RL_IDLE;
                batch_n = '0;
                pend_n  = '0;
            end
        endcase
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_valid_o <= 1'b0;
            tx_slot_o  <= '0;
            tx_data_o  <= '0;
            last_q     <= 1'b1;
        end else begin
            tx_valid_o <= (st_q == RL_DRAIN);
            tx_slot_o  <= gidx;
            tx_data_o  <= bufs_i[gidx*MSG_W +: MSG_W];
            last_q     <= (st_q != RL_DRAIN) || (rest == '0);
        end
    end

    // R8
    drain_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == RL_DRAIN) |=> tx_valid_o);

    // R8
    order_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid_o && $past(tx_valid_o) && !$past(last_q))
            |-> (tx_slot_o > $past(tx_slot_o)));

endmodule

// File: rtl/tts_sched.sv
module tts_sched
    import tts_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int MSG_W     = 32,
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [TIME_W-1:0]    gtime_i,
    input  logic                 cfg_we_i,
    input  logic [SLOT_W-1:0]    cfg_slot_i,
    input  logic                 cfg_en_i,
    input  logic [CODE_W-1:0]    cfg_code_i,
    input  logic [PH_W-1:0]      cfg_phase_i,
    input  logic                 wr_en_i,
    input  logic [SLOT_W-1:0]    wr_slot_i,
    input  logic [MSG_W-1:0]     wr_data_i,
    input  logic [SLOT_W-1:0]    rd_slot_i,
    output logic [MSG_W-1:0]     rd_data_o,
    output logic [NUM_SLOTS-1:0] trig_o,
    output logic                 tx_valid_o,
    output logic [SLOT_W-1:0]    tx_slot_o,
    output logic [MSG_W-1:0]     tx_data_o
);

    slot_cfg_t                  cfg_word;
    logic [NUM_SLOTS-1:0]       rel_req;
    logic [MSG_W-1:0]           buf_arr [NUM_SLOTS];
    logic [NUM_SLOTS*MSG_W-1:0] buf_flat;

    assign cfg_word = '{en: cfg_en_i, code: cfg_code_i, phase: cfg_phase_i};

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        logic cfg_hit, wr_hit;
        assign cfg_hit = cfg_we_i && (cfg_slot_i == SLOT_W'(s));
        assign wr_hit  = wr_en_i  && (wr_slot_i  == SLOT_W'(s));

        tts_slot #(.MSG_W(MSG_W)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .gtime_i   (gtime_i),
            .cfg_hit_i (cfg_hit),
            .cfg_i     (cfg_word),
            .wr_hit_i  (wr_hit),
            .wr_data_i (wr_data_i),
            .trig_o    (trig_o[s]),
            .rel_req_o (rel_req[s]),
            .buf_o     (buf_arr[s])
        );

        assign buf_flat[s*MSG_W +: MSG_W] = buf_arr[s];
    end

    assign rd_data_o = buf_arr[rd_slot_i];

    tts_release #(.NUM_SLOTS(NUM_SLOTS), .MSG_W(MSG_W)) u_release (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (rel_req),
        .bufs_i     (buf_flat),
        .tx_valid_o (tx_valid_o),
        .tx_slot_o  (tx_slot_o),
        .tx_data_o  (tx_data_o)
    );

endmodule

// File: tb/tts_sched_tb_top.sv
module tts_sched_tb_top;

    localparam int NS = 4;
    localparam int MW = 32;
    localparam int SW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [63:0]   gtime = '0;
    logic          cfg_we = 1'b0;
    logic [SW-1:0] cfg_slot = '0;
    logic          cfg_en = 1'b0;
    logic [3:0]    cfg_code = '0;
    logic [11:0]   cfg_phase = '0;
    logic          wr_en = 1'b0;
    logic [SW-1:0] wr_slot = '0;
    logic [MW-1:0] wr_data = '0;
    logic [SW-1:0] rd_slot = '0;
    logic [MW-1:0] rd_data;
    logic [NS-1:0] trig;
    logic          tx_valid;
    logic [SW-1:0] tx_slot;
    logic [MW-1:0] tx_data;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;

    always #10 clk = ~clk;

    tts_sched #(.NUM_SLOTS(NS), .MSG_W(MW)) dut_i (
        .clk(clk), .rst_n(rst_n), .gtime_i(gtime),
        .cfg_we_i(cfg_we), .cfg_slot_i(cfg_slot), .cfg_en_i(cfg_en),
        .cfg_code_i(cfg_code), .cfg_phase_i(cfg_phase),
        .wr_en_i(wr_en), .wr_slot_i(wr_slot), .wr_data_i(wr_data),
        .rd_slot_i(rd_slot), .rd_data_o(rd_data), .trig_o(trig),
        .tx_valid_o(tx_valid), .tx_slot_o(tx_slot), .tx_data_o(tx_data)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // reference match: period bit 25-c, lowest compared bit 13-c
    function automatic bit mdl(input logic [63:0] g, input int c, input logic [11:0] ph);
        int lo;
        int pb;
        lo = 13 - c;
        pb = 25 - c;
        if (lo >= 0) return ((g >> lo) & 64'hFFF) == 64'(ph);
        return (g & ((64'd1 << pb) - 1)) == (64'(ph) >> (-lo));
    endfunction

    function automatic logic [63:0] mk(input logic [63:0] noise, input int c,
                                       input logic [11:0] ph);
        int lo;
        int pb;
        logic [63:0] fm;
        logic [63:0] v;
        lo = 13 - c;
        pb = 25 - c;
        if (lo >= 0) begin
            fm = 64'hFFF << lo;
            v  = 64'(ph) << lo;
        end else begin
            fm = (64'd1 << pb) - 1;
            v  = 64'(ph) >> (-lo);
        end
        return (noise & ~fm) | (v & fm);
    endfunction

    task automatic cfg(input int s, input bit en, input int c, input logic [11:0] ph);
        @(negedge clk);
        cfg_we = 1'b1; cfg_slot = SW'(s); cfg_en = en;
        cfg_code = 4'(c); cfg_phase = ph;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wr(input int s, input logic [MW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_slot = SW'(s); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic step(input logic [63:0] g);
        @(negedge clk);
        gtime = g;
        #2;
    endtask

    task automatic expect_tx(input int s, input logic [MW-1:0] d, input string tag);
        @(negedge clk);
        #2;
        chk(tx_valid == 1'b1, tag, 64'(tx_valid), 64'd1);
        chk(tx_slot == SW'(s), tag, 64'(tx_slot), 64'(s));
        chk(tx_data == d, tag, 64'(tx_data), 64'(d));
    endtask

    task automatic expect_no_tx(input string tag);
        @(negedge clk);
        #2;
        chk(tx_valid == 1'b0, tag, 64'(tx_valid), 64'd0);
    endtask

    // every period code: field position, ignored upper bits, edge qualification
    task automatic sweep_codes();
        logic [63:0] noise, noise2, g, gn;
        logic [11:0] ph;
        int pb;
        for (int c = 0; c < 16; c++) begin
            pb     = 25 - c;
            ph     = 12'hA5F ^ 12'(c * 37);
            noise  = 64'hDEAD_BEEF_0123_4567 ^ (64'(c) * 64'h9E37_79B9_7F4A_7C15);
            noise2 = noise ^ ~((64'd1 << pb) - 1);
            g      = mk(noise, c, ph);
            gn     = g ^ (64'd1 << (pb - 1));
            cfg(0, 1'b1, c, ph);
            step(gn);
            chk(trig[0] == mdl(gn, c, ph), "R1 nonmatch", 64'(trig[0]), 64'(mdl(gn, c, ph)));
            step(g);
            chk(trig[0] == 1'b1, (c >= 14) ? "R3 match" : "R1 match", 64'(trig[0]), 64'd1);
            step(g);
            chk(trig[0] == 1'b0, "R4 held match", 64'(trig[0]), 64'd0);
            step(gn);
            chk(trig[0] == 1'b0, "R4 released", 64'(trig[0]), 64'd0);
            step(mk(noise2, c, ph));
            chk(trig[0] == 1'b1, "R2 upper bits ignored", 64'(trig[0]), 64'd1);
            if (c >= 14) begin
                cfg(0, 1'b1, c, ph ^ 12'(c - 13));
                step(gn);
                step(g);
                chk(trig[0] == 1'b1, "R3 low phase bits ignored", 64'(trig[0]), 64'd1);
            end
        end
    endtask

    // exhaustive walk over every compared time value
    task automatic sweep_low(input int c, input logic [11:0] ph);
        logic [63:0] base, g;
        bit prev, m;
        int pb;
        pb   = 25 - c;
        base = 64'h0000_1234_5000_0000;
        cfg(0, 1'b1, c, ph);
        step(mk(base, c, ph) ^ (64'd1 << (pb - 1)));
        prev = 1'b0;
        for (int i = 0; i < (1 << pb); i++) begin
            g = base | 64'(i);
            m = mdl(g, c, ph);
            step(g);
            chk(trig[0] == (m && !prev), (c >= 14) ? "R3 sweep" : "R4 sweep",
                64'(trig[0]), 64'(m && !prev));
            prev = m;
        end
    endtask

    task automatic release_tests();
        logic [63:0] g, gn;
        g  = mk(64'h0000_0042_0000_0000, 6, 12'h123);
        gn = g ^ (64'd1 << 18);
        for (int s = 0; s < NS; s++) cfg(s, 1'b1, 6, 12'h123);
        step(gn);
        wr(0, 32'hAAAA_0000);
        wr(1, 32'hBBBB_1111);
        wr(3, 32'hDDDD_3333);
        step(g);
        chk(trig == 4'hF, "R8 common trigger", 64'(trig), 64'hF);
        expect_no_tx("R7 latency");
        expect_tx(0, 32'hAAAA_0000, "R8 first");
        expect_tx(1, 32'hBBBB_1111, "R8 second");
        expect_tx(3, 32'hDDDD_3333, "R8 third");
        expect_no_tx("R7 empty slot 2 silent");
        // held marks consumed: a new trigger sends nothing
        step(gn);
        step(g);
        chk(trig == 4'hF, "R7 retrigger", 64'(trig), 64'hF);
        expect_no_tx("R7 consumed");
        expect_no_tx("R7 consumed");
        expect_no_tx("R7 consumed");
        rd_slot = 2'd1;
        #1;
        chk(rd_data == 32'hBBBB_1111, "R6 state kept", 64'(rd_data), 64'hBBBB_1111);
        // disable slot 1, reload 0/1/2
        cfg(1, 1'b0, 6, 12'h123);
        step(gn);
        wr(2, 32'hCCCC_2222);
        wr(1, 32'hBBBB_9999);
        wr(0, 32'hAAAA_7777);
        step(g);
        chk(trig == 4'b1101, "R5 disabled slot", 64'(trig), 64'hD);
        expect_no_tx("R7 latency");
        expect_tx(0, 32'hAAAA_7777, "R8 first");
        expect_tx(2, 32'hCCCC_2222, "R8 second");
        expect_no_tx("R5 disabled not sent");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        // R9: defaults would match gtime 0 if enabled
        chk(trig == '0, "R9 trig", 64'(trig), 64'd0);
        chk(tx_valid == 1'b0, "R9 tx_valid", 64'(tx_valid), 64'd0);
        for (int s = 0; s < NS; s++) begin
            rd_slot = SW'(s);
            #1;
            chk(rd_data == '0, "R9 buffer", 64'(rd_data), 64'd0);
        end
        step(64'd0);
        chk(trig == '0, "R9 disabled", 64'(trig), 64'd0);

        // R6 overwrite
        wr(3, 32'h1357_9BDF);
        rd_slot = 2'd3;
        #1;
        chk(rd_data == 32'h1357_9BDF, "R6 write", 64'(rd_data), 64'h1357_9BDF);
        wr(3, 32'h0246_8ACE);
        #1;
        chk(rd_data == 32'h0246_8ACE, "R6 overwrite", 64'(rd_data), 64'h0246_8ACE);
        rd_slot = 2'd2;
        #1;
        chk(rd_data == '0, "R6 other slot", 64'(rd_data), 64'd0);
        wr(3, 32'h0);

        sweep_codes();
        sweep_low(15, 12'h3A9);
        sweep_low(14, 12'h5C3);
        sweep_low(13, 12'h9E1);
        release_tests();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule